// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block drives the control strobes of a parallel NAND flash device. One operation runs at a time: a command latch, an address latch, a data write or a data read. For each one the block produces the latch-enable level, an active-low write or read strobe, and the data-bus output enable. Every phase length is a count of master clock cycles taken from timing fields that are loaded in parallel. Reads return the captured byte together with a one-cycle completion pulse.

Three extra delays cover the turnaround rules of the flash. A data write that directly follows an address latch waits long enough that its write strobe rises no sooner than an address-to-data count after the write begins. A read that directly follows an address latch, or a command latch, waits so that its read strobe falls no sooner than an address-to-read count, or a command-to-read count, after the read begins. The wait is computed once, when the request is accepted, and it takes into account the setup time that the operation already has.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset and until the first `cfg_load`, `req_ready` stays low, requests are not accepted, no strobe moves and `done` stays low.
- R2: `cfg_load` updates the timing fields only while no operation is running. A load pulsed during an operation is ignored, and later operations keep the old timing.
- R3: `req_ready` is high exactly when the block is configured and idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_op` encodes 0 as command latch, 1 as address latch, 2 as data write and 3 as data read.
- R4: Command, address and write operations share one write waveform. WE# stays high for `cfg_we_setup` cycles, is low for the pulse count (a pulse of 0 counts as 1), and is then high for a hold of `cfg_we_cycle` minus setup minus the effective pulse, floored at zero.
- R5: CLE is high during every setup, pulse and hold cycle of a command operation. ALE is high during those cycles of an address operation. Neither is high during data operations, during any wait gap, or at the same time as the other.
- R6: A read builds its RE# waveform the same way from `cfg_re_setup`, `cfg_re_pulse` and `cfg_re_cycle`. WE# stays high for the whole read.
- R7: `rdata` takes `nand_dq_in` at the clock edge that ends the last low cycle of RE#, and it holds that value until the next read captures a new one.
- R8: A data write accepted directly after an address latch starts with an idle gap of max(`cfg_addr_to_data` − setup − effective pulse, 0) cycles.
- R9: A read accepted directly after an address latch starts with an idle gap of max(`cfg_ale_to_re` − `cfg_re_setup`, 0) cycles.
- R10: A read accepted directly after a command latch starts with an idle gap of max(`cfg_cle_to_re` − `cfg_re_setup`, 0) cycles. All other op pairs have no gap.
- R11: `nand_dq_oe` is high during every setup, pulse and hold cycle of command, address and write operations, and `nand_dq_out` then carries the request's `req_wdata`. It is low during reads and gaps.
- R12: `done` is high for exactly one cycle, the first cycle after the final phase. An operation therefore lasts gap + setup + pulse + hold cycles after acceptance.
- R13: WE# and RE# are never low together. While idle, both are high and CLE, ALE and the output enable are low, including directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads all timing fields (only while idle) |
| cfg_we_setup | input | TW | WE# setup cycles |
| cfg_we_pulse | input | TW | WE# low cycles (0 acts as 1) |
| cfg_we_cycle | input | TW | Total write strobe cycle length |
| cfg_re_setup | input | TW | RE# setup cycles |
| cfg_re_pulse | input | TW | RE# low cycles (0 acts as 1) |
| cfg_re_cycle | input | TW | Total read strobe cycle length |
| cfg_addr_to_data | input | TW | Minimum cycles from write start to first WE# rise after an address latch |
| cfg_ale_to_re | input | TW | Minimum cycles from read start to RE# fall after an address latch |
| cfg_cle_to_re | input | TW | Minimum cycles from read start to RE# fall after a command latch |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (0 cmd, 1 addr, 2 write, 3 read) |
| req_wdata | input | DW | Byte driven on the bus for cmd, addr and write |
| req_ready | output | 1 | Configured and idle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last byte captured by a read |
| nand_cle | output | 1 | Command latch enable, active high |
| nand_ale | output | 1 | Address latch enable, active high |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DW | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DW | Data bus input value |

## Verification
Random timing sets are reloaded every few operations and paired with random op sequences. This covers every pair of previous and current op, so a missing or misapplied gap shows up as a shifted strobe edge. The directed cases set a zero pulse, a cycle shorter than setup plus pulse, and a zero setup. They also set gap counts both above and below the setup time already present, which tells the saturating arithmetic apart from a plain subtraction or a fixed delay. During a read the bus input changes every cycle, so a capture one edge early or late yields a different byte. A load pulsed in mid-operation and requests made before any load show whether configuration and acceptance are properly gated.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } nsg_op_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_GAP   = 3'd1,
    PH_SETUP = 3'd2,
    PH_PULSE = 3'd3,
    PH_HOLD  = 3'd4
  } nsg_phase_e;

  // a - b, floored at zero
  function automatic int unsigned sat_sub(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

  // strobe low time never shorter than one cycle
  function automatic int unsigned pulse_len(int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

  // remainder of the strobe cycle after setup and pulse
  function automatic int unsigned hold_len(int unsigned s, int unsigned p, int unsigned c);
    return sat_sub(c, s + pulse_len(p));
  endfunction

  // idle wait inserted before an op, depending on the op accepted before it
  function automatic int unsigned gap_len(nsg_op_e op, nsg_op_e prev,
                                          int unsigned a2d, int unsigned a2r, int unsigned c2r,
                                          int unsigned ws, int unsigned wp, int unsigned rs);
    if (op == OP_WRITE && prev == OP_ADDR) return sat_sub(a2d, ws + pulse_len(wp));
    if (op == OP_READ  && prev == OP_ADDR) return sat_sub(a2r, rs);
    if (op == OP_READ  && prev == OP_CMD)  return sat_sub(c2r, rs);
    return 0;
  endfunction

endpackage

// File: rtl/nsg_cfg_store.sv
module nsg_cfg_store #(
  parameter int unsigned TW = 6,
  parameter int unsigned NF = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic                   allow_i,
  input  logic [NF-1:0][TW-1:0]  fld_i,
  output logic [NF-1:0][TW-1:0]  fld_o,
  output logic                   valid_o
);

  logic take_w;
  assign take_w = load_i & allow_i;

  for (genvar gi = 0; gi < NF; gi++) begin : g_fld
    logic [TW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      r_q <= '0;
      else if (take_w) r_q <= fld_i[gi];
    end
    assign fld_o[gi] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_o <= 1'b0;
    else if (take_w) valid_o <= 1'b1;
  end

endmodule

// File: rtl/nsg_phase_seq.sv
module nsg_phase_seq
  import nsg_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] gap_i,
  input  logic [LW-1:0] setup_i,
  input  logic [LW-1:0] pulse_i,
  input  logic [LW-1:0] hold_i,
  output nsg_phase_e    phase_o,
  output logic          step_end_o,
  output logic          finish_o
);

  localparam logic [LW-1:0] ONE = LW'(1);

  nsg_phase_e    ph_q, ph_first, ph_next;
  logic [LW-1:0] cnt_q, setup_q, pulse_q, hold_q;
  logic [LW-1:0] first_len, next_len;

  // first phase with a non-zero length; pulse is never zero
  always_comb begin
    if (gap_i != '0) begin
      ph_first = PH_GAP;   first_len = gap_i;
    end else if (setup_i != '0) begin
      ph_first = PH_SETUP; first_len = setup_i;
    end else begin
      ph_first = PH_PULSE; first_len = pulse_i;
    end
  end

  always_comb begin
    ph_next  = PH_IDLE;
    next_len = '0;
    case (ph_q)
      PH_GAP: begin
        if (setup_q != '0) begin ph_next = PH_SETUP; next_len = setup_q; end
        else               begin ph_next = PH_PULSE; next_len = pulse_q; end
      end
      PH_SETUP: begin ph_next = PH_PULSE; next_len = pulse_q; end
      PH_PULSE: if (hold_q != '0) begin ph_next = PH_HOLD; next_len = hold_q; end
      default: ;
    endcase
  end

  assign step_end_o = (ph_q != PH_IDLE) && (cnt_q == '0);
  assign finish_o   = step_end_o && (ph_next == PH_IDLE);
  assign phase_o    = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      setup_q <= '0;
      pulse_q <= '0;
      hold_q  <= '0;
    end else if (start_i) begin
      ph_q    <= ph_first;
      cnt_q   <= first_len - ONE;
      setup_q <= setup_i;
      pulse_q <= pulse_i;
      hold_q  <= hold_i;
    end else if (step_end_o) begin
      ph_q  <= ph_next;
      cnt_q <= (ph_next == PH_IDLE) ? '0 : (next_len - ONE);
    end else if (ph_q != PH_IDLE) begin
      cnt_q <= cnt_q - ONE;
    end
  end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int unsigned TW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [TW-1:0] cfg_we_setup,
  input  logic [TW-1:0] cfg_we_pulse,
  input  logic [TW-1:0] cfg_we_cycle,
  input  logic [TW-1:0] cfg_re_setup,
  input  logic [TW-1:0] cfg_re_pulse,
  input  logic [TW-1:0] cfg_re_cycle,
  input  logic [TW-1:0] cfg_addr_to_data,
  input  logic [TW-1:0] cfg_ale_to_re,
  input  logic [TW-1:0] cfg_cle_to_re,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [DW-1:0] nand_dq_in
);

  localparam int unsigned LW = TW + 2;
  localparam int unsigned NF = 9;
  localparam int unsigned F_WS = 0, F_WP = 1, F_WC = 2;
  localparam int unsigned F_RS = 3, F_RP = 4, F_RC = 5;
  localparam int unsigned F_A2D = 6, F_A2R = 7, F_C2R = 8;

  logic [NF-1:0][TW-1:0] cfg_in, cfg_q;
  logic                  cfg_ok;
  nsg_phase_e            phase_w;
  logic                  idle_w, accept_w, step_end_w, finish_w, rd_cap_w, strobe_ph_w;
  nsg_op_e               op_q, new_op;
  logic [DW-1:0]         wdata_q;
  logic [LW-1:0]         len_gap, len_setup, len_pulse, len_hold;
  int unsigned           s_sel, p_sel, c_sel;

  assign cfg_in = {cfg_cle_to_re, cfg_ale_to_re, cfg_addr_to_data,
                   cfg_re_cycle, cfg_re_pulse, cfg_re_setup,
                   cfg_we_cycle, cfg_we_pulse, cfg_we_setup};

  nsg_cfg_store #(.TW(TW), .NF(NF)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cfg_load),
    .allow_i (idle_w),
    .fld_i   (cfg_in),
    .fld_o   (cfg_q),
    .valid_o (cfg_ok)
  );

  assign idle_w    = (phase_w == PH_IDLE);
  assign req_ready = idle_w & cfg_ok;
  assign accept_w  = req_valid & req_ready;
  assign new_op    = nsg_op_e'(req_op);

  // phase lengths for the incoming request
  always_comb begin
    if (new_op == OP_READ) begin
      s_sel = 32'(cfg_q[F_RS]); p_sel = 32'(cfg_q[F_RP]); c_sel = 32'(cfg_q[F_RC]);
    end else begin
      s_sel = 32'(cfg_q[F_WS]); p_sel = 32'(cfg_q[F_WP]); c_sel = 32'(cfg_q[F_WC]);
    end
    len_setup = LW'(s_sel);
    len_pulse = LW'(pulse_len(p_sel));
    len_hold  = LW'(hold_len(s_sel, p_sel, c_sel));
    len_gap   = LW'(gap_len(new_op, op_q,
                            32'(cfg_q[F_A2D]), 32'(cfg_q[F_A2R]), 32'(cfg_q[F_C2R]),
                            32'(cfg_q[F_WS]), 32'(cfg_q[F_WP]), 32'(cfg_q[F_RS])));
  end

  nsg_phase_seq #(.LW(LW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (accept_w),
    .gap_i      (len_gap),
    .setup_i    (len_setup),
    .pulse_i    (len_pulse),
    .hold_i     (len_hold),
    .phase_o    (phase_w),
    .step_end_o (step_end_w),
    .finish_o   (finish_w)
  );

  // op_q also serves as "previous op" for the next gap decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_READ;
      wdata_q <= '0;
    end else if (accept_w) begin
      op_q    <= new_op;
      wdata_q <= req_wdata;
    end
  end

  assign rd_cap_w = (phase_w == PH_PULSE) && step_end_w && (op_q == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish_w;
      if (rd_cap_w) rdata <= nand_dq_in;
    end
  end

  assign strobe_ph_w = (phase_w == PH_SETUP) || (phase_w == PH_PULSE) || (phase_w == PH_HOLD);
  assign nand_cle    = strobe_ph_w && (op_q == OP_CMD);
  assign nand_ale    = strobe_ph_w && (op_q == OP_ADDR);
  assign nand_dq_oe  = strobe_ph_w && (op_q != OP_READ);
  assign nand_dq_out = wdata_q;
  assign nand_we_n   = !((phase_w == PH_PULSE) && (op_q != OP_READ));
  assign nand_re_n   = !((phase_w == PH_PULSE) && (op_q == OP_READ));

endmodule

// File: rtl/nsg_checker.sv
module nsg_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle,
  input logic          rd_cap,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic          cle,
  input logic          ale,
  input logic          we_n,
  input logic          re_n,
  input logic          dq_oe
);

  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (we_n && re_n && !cle && !ale && !dq_oe));

  p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idle && $past(!idle)));

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cap |=> $stable(rdata));

  p_no_drive_in_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

endmodule

bind nand_strobe_gen nsg_checker #(.DW(DW)) u_nsg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle      (idle_w),
  .rd_cap    (rd_cap_w),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .rdata     (rdata),
  .cle       (nand_cle),
  .ale       (nand_ale),
  .we_n      (nand_we_n),
  .re_n      (nand_re_n),
  .dq_oe     (nand_dq_oe)
);

// File: tb/test_nand_strobe_gen.sv
module test_nand_strobe_gen;

  localparam int TW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [TW-1:0] cfg_we_setup = '0, cfg_we_pulse = '0, cfg_we_cycle = '0;
  logic [TW-1:0] cfg_re_setup = '0, cfg_re_pulse = '0, cfg_re_cycle = '0;
  logic [TW-1:0] cfg_addr_to_data = '0, cfg_ale_to_re = '0, cfg_cle_to_re = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done;
  logic [DW-1:0] rdata, nand_dq_out;
  logic          nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [DW-1:0] nand_dq_in = '0;

  int n_chk = 0;
  int n_err = 0;

  // bench model of the loaded timing
  int m_ws, m_wp, m_wc, m_rs, m_rp, m_rc, m_a2d, m_a2r, m_c2r;
  int last_op = 3;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  nand_strobe_gen #(.TW(TW), .DW(DW)) i_nand_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse), .cfg_we_cycle(cfg_we_cycle),
    .cfg_re_setup(cfg_re_setup), .cfg_re_pulse(cfg_re_pulse), .cfg_re_cycle(cfg_re_cycle),
    .cfg_addr_to_data(cfg_addr_to_data), .cfg_ale_to_re(cfg_ale_to_re),
    .cfg_cle_to_re(cfg_cle_to_re),
    .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_low(int p);
    int r = p;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int exp_rest(int s, int p, int c);
    int used = s + exp_low(p);
    if (c <= used) return 0;
    return c - used;
  endfunction

  // waiting cycles before the strobe setup; 2=write, 3=read, 1=addr, 0=cmd
  function automatic int exp_wait(int op, int prev);
    int need = 0, have = 0;
    if (op == 2 && prev == 1) begin need = m_a2d; have = m_ws + exp_low(m_wp); end
    else if (op == 3 && prev == 1) begin need = m_a2r; have = m_rs; end
    else if (op == 3 && prev == 0) begin need = m_c2r; have = m_rs; end
    return (need > have) ? need - have : 0;
  endfunction

  task automatic load_cfg(bit upd, int ws, int wp, int wc, int rs, int rp, int rc,
                          int a2d, int a2r, int c2r);
    cfg_we_setup = TW'(ws); cfg_we_pulse = TW'(wp); cfg_we_cycle = TW'(wc);
    cfg_re_setup = TW'(rs); cfg_re_pulse = TW'(rp); cfg_re_cycle = TW'(rc);
    cfg_addr_to_data = TW'(a2d); cfg_ale_to_re = TW'(a2r); cfg_cle_to_re = TW'(c2r);
    if (upd) begin
      m_ws = ws; m_wp = wp; m_wc = wc; m_rs = rs; m_rp = rp; m_rc = rc;
      m_a2d = a2d; m_a2r = a2r; m_c2r = c2r;
    end
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run_op(int op, logic [DW-1:0] wd, logic [DW-1:0] rd);
    int s, p, h, g, wt, first_low, low_cnt, qual, bad, done_at, exp_rd;
    string gtag;
    bit act_low, oth_low;
    if (op == 3) begin s = m_rs; p = exp_low(m_rp); h = exp_rest(m_rs, m_rp, m_rc); end
    else         begin s = m_ws; p = exp_low(m_wp); h = exp_rest(m_ws, m_wp, m_wc); end
    g = exp_wait(op, last_op);
    gtag = (op == 3) ? "R6" : "R4";
    if (g > 0) gtag = (op == 2) ? "R8" : ((last_op == 1) ? "R9" : "R10");
    wt = 0;
    while (!req_ready && wt < 200) begin @(negedge clk); wt++; end
    chk(req_ready, "R3", "ready before issue", int'(req_ready), 1);
    req_valid = 1'b1; req_op = 2'(op); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    first_low = 0; low_cnt = 0; qual = 0; bad = 0; done_at = 0;
    for (int i = 1; i <= 400; i++) begin
      nand_dq_in = rd ^ DW'(i);
      if (done) begin done_at = i; break; end
      act_low = (op == 3) ? !nand_re_n : !nand_we_n;
      oth_low = (op == 3) ? !nand_we_n : !nand_re_n;
      if (act_low) begin low_cnt++; if (first_low == 0) first_low = i; end
      if (oth_low) bad++;
      case (op)
        0: if (nand_cle && nand_dq_oe && !nand_ale) qual++;
        1: if (nand_ale && nand_dq_oe && !nand_cle) qual++;
        2: if (nand_dq_oe && !nand_cle && !nand_ale) qual++;
        default: if (nand_cle || nand_ale || nand_dq_oe) qual++;
      endcase
      if (op != 3 && nand_dq_oe && nand_dq_out != wd) bad++;
      @(negedge clk);
    end
    chk(first_low == g + s + 1, gtag, "strobe fall cycle", first_low, g + s + 1);
    chk(low_cnt == p, (op == 3) ? "R6" : "R4", "strobe low cycles", low_cnt, p);
    chk(done_at == g + s + p + h + 1, "R12", "done cycle", done_at, g + s + p + h + 1);
    chk(qual == ((op == 3) ? 0 : s + p + h), (op == 2) ? "R11" : "R5",
        "latch/oe cycles", qual, (op == 3) ? 0 : s + p + h);
    chk(bad == 0, "R13", "wrong strobe or bus value cycles", bad, 0);
    if (op == 3) begin
      exp_rd = int'(rd ^ DW'(g + s + p));
      chk(int'(rdata) == exp_rd, "R7", "read data", int'(rdata), exp_rd);
    end
    last_op = op;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !done,
        "R13", "idle strobes after reset", 0, 1);
    // R1 unconfigured: requests refused
    chk(!req_ready, "R1", "ready while unconfigured", int'(req_ready), 0);
    bad = 0;
    req_valid = 1'b1; req_op = 2'd2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (req_ready || done || !nand_we_n || !nand_re_n || nand_cle || nand_ale || nand_dq_oe) bad++;
    end
    req_valid = 1'b0;
    chk(bad == 0, "R1", "activity while unconfigured", bad, 0);

    // directed corners
    load_cfg(1, 2, 3, 9, 1, 2, 6, 10, 5, 4);
    chk(req_ready, "R3", "ready after load", int'(req_ready), 1);
    run_op(0, 8'h70, 8'h00);            // cmd, hold 4
    run_op(3, 8'h00, 8'h5A);            // read after cmd: gap 3 (R10)
    run_op(1, 8'h11, 8'h00);            // addr
    run_op(2, 8'hC3, 8'h00);            // write after addr: gap 5 (R8)
    run_op(2, 8'h3C, 8'h00);            // write after write: no gap
    run_op(1, 8'h22, 8'h00);
    run_op(3, 8'h00, 8'hA5);            // read after addr: gap 4 (R9)
    load_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);   // zero setup, pulse 0 acts as 1
    run_op(2, 8'h01, 8'h00);
    run_op(3, 8'h00, 8'h80);
    load_cfg(1, 3, 4, 2, 2, 5, 1, 1, 1, 1);   // cycle below setup+pulse, small gaps
    run_op(1, 8'h44, 8'h00);
    run_op(2, 8'h55, 8'h00);
    run_op(0, 8'h66, 8'h00);
    run_op(3, 8'h00, 8'h99);

    // R2: load while busy is ignored
    fork
      run_op(0, 8'hE1, 8'h00);
      begin
        @(negedge clk); @(negedge clk);
        load_cfg(0, 7, 7, 30, 7, 7, 30, 20, 20, 20);
      end
    join
    run_op(3, 8'h00, 8'h3E);            // still old timing (R2)
    run_op(2, 8'h7E, 8'h00);

    // random sequences
    for (int blk = 0; blk < 8; blk++) begin
      load_cfg(1, $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 15),
               $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 15),
               $urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12));
      for (int n = 0; n < 16; n++)
        run_op($urandom_range(0, 3), DW'($urandom), DW'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule